// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This block carries out the four single-bit operations of a processor datapath: examine a bit, invert it, force it to zero or force it to one. The operand reaches the block already fetched. It is either a full 32-bit data-register value or one memory byte, which sits in the low eight bits of the operand bus. The bit number comes either from a register or from an immediate field. The block forms a one-hot mask from the bit number and applies the selected operation. It then reports four things: the modified operand, the new zero flag (taken from the bit before the change), whether a write-back is needed, and how many execution cycles the operation costs.

A request is presented with `in_valid` high for one clock. The block registers the result, and the result appears one clock later with `out_valid` high. The outputs keep their last values until the next request arrives. Address generation, the memory access and the other condition flags stay with the surrounding datapath. The zero flag is the only flag this block produces.

Top module: `bitop_unit`

## Requirements
- R1: Operation code 0 (test) returns the operand unchanged on `result` and drives `wr_en` low.
- R2: For a register operand (`opnd_is_reg`=1), the bit index is `bit_num` modulo 32, and all 32 bits of the operand take part.
- R3: For a memory operand (`opnd_is_reg`=0), the bit index is `bit_num` modulo 8, and only bits 7:0 can change; `result[31:8]` equals `operand[31:8]`.
- R4: `z_flag` is 1 when the selected bit of the operand was 0 before the operation, and 0 when it was 1, for every operation code.
- R5: Operation code 1 (change) inverts the selected bit and leaves all others.
- R6: Operation code 2 (clear) forces the selected bit to 0 and leaves all others.
- R7: Operation code 3 (set) forces the selected bit to 1 and leaves all others.
- R8: `wr_en` is 1 for operation codes 1, 2 and 3.
- R9: With a register-supplied bit number (`cnt_is_reg`=1), `cycles` is 4 for test and 8 for clear (each plus 2 when `opnd_is_reg`=1), and 8 for change and set.
- R10: With an immediate bit number (`cnt_is_reg`=0), `cycles` is 8 for test and 12 for clear (each plus 2 when `opnd_is_reg`=1), and 12 for change and set.
- R11: Outputs for a request sampled with `in_valid`=1 at a rising edge are visible after that edge, with `out_valid`=1. When `in_valid` is 0, `out_valid` drops after the next edge and `result`, `z_flag`, `wr_en` and `cycles` hold.
- R12: While `rst_n` is low, `out_valid`, `result`, `z_flag`, `wr_en` and `cycles` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; must be released synchronously to `clk` |
| in_valid | input | 1 | Request strobe; loads the output registers |
| op_type | input | 2 | 0 test, 1 change, 2 clear, 3 set |
| bit_num | input | NUM_W (8) | Bit number before reduction |
| cnt_is_reg | input | 1 | 1: bit number came from a register; 0: from an immediate |
| opnd_is_reg | input | 1 | 1: 32-bit data-register operand; 0: memory byte in bits 7:0 |
| operand | input | DATA_W (32) | Operand value before the operation |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | DATA_W (32) | Operand after the operation |
| z_flag | output | 1 | New zero flag |
| wr_en | output | 1 | Result must be written back |
| cycles | output | 5 | Execution cycle cost |

## Verification
The hardest cases to reach from the ports are the ones where the reduction step decides the outcome. These are bit numbers of 32 and above on a register operand, and bit numbers of 8 and above on a byte operand. In these cases an unreduced index would select a different bit, or a bit outside the operand. The stimulus table places operand bits so that only the correctly reduced index hits a one (or a zero) and produces the expected flag and value. Examples are bit 35 on a value with only bit 3 set, bit 255 on a byte with only bit 7 set, and bit 128 on a byte with bit 0 set. Byte operands also carry non-zero upper bits, so that any leak of the mask above bit 7 shows up on `result`.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    BOP_TEST = 2'd0,
    BOP_FLIP = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_SET  = 2'd3
  } bitop_e;

  localparam int unsigned CYC_W          = 5;
  localparam int unsigned COST_TEST_BASE = 4;
  localparam int unsigned COST_MOD_BASE  = 8;
  localparam int unsigned COST_IMM_ADD   = 4;
  localparam int unsigned COST_DREG_ADD  = 2;

endpackage

// File: rtl/bitop_mask_dec.sv
module bitop_mask_dec #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_W  = 8
) (
  input  logic [NUM_W-1:0]  bit_num,
  input  logic              is_reg,
  output logic [DATA_W-1:0] mask
);
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0] idx;
  logic             unused_hi;

  // Modulo by power of two: keep only the low index bits.
  always_comb begin
    if (is_reg) idx = bit_num[IDX_W-1:0];
    else        idx = {{(IDX_W-BIDX_W){1'b0}}, bit_num[BIDX_W-1:0]};
  end

  assign unused_hi = ^bit_num[NUM_W-1:IDX_W];

  for (genvar g = 0; g < DATA_W; g++) begin : g_dec
    assign mask[g] = (idx == IDX_W'(g));
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  bitop_e            op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] res,
  output logic              zero,
  output logic              wr
);
  always_comb begin
    zero = ~|(opnd & mask);
    wr   = (op != BOP_TEST);
    unique case (op)
      BOP_FLIP: res = opnd ^ mask;
      BOP_CLR:  res = opnd & ~mask;
      BOP_SET:  res = opnd | mask;
      default:  res = opnd;
    endcase
  end

endmodule

// File: rtl/bitop_cost.sv
module bitop_cost
  import bitop_pkg::*;
(
  input  bitop_e           op,
  input  logic             cnt_is_reg,
  input  logic             opnd_is_reg,
  output logic [CYC_W-1:0] cycles
);
  localparam logic [CYC_W-1:0] C_TEST = CYC_W'(COST_TEST_BASE);
  localparam logic [CYC_W-1:0] C_MOD  = CYC_W'(COST_MOD_BASE);
  localparam logic [CYC_W-1:0] C_IMM  = CYC_W'(COST_IMM_ADD);
  localparam logic [CYC_W-1:0] C_DREG = CYC_W'(COST_DREG_ADD);

  logic [CYC_W-1:0] base;
  logic [CYC_W-1:0] imm_add;
  logic [CYC_W-1:0] dreg_add;

  always_comb begin
    base     = (op == BOP_TEST) ? C_TEST : C_MOD;
    imm_add  = cnt_is_reg ? '0 : C_IMM;
    // Only test and clear pay extra for a register operand.
    dreg_add = (opnd_is_reg && (op == BOP_TEST || op == BOP_CLR)) ? C_DREG : '0;
    cycles   = base + imm_add + dreg_add;
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op_type,
  input  logic [NUM_W-1:0]  bit_num,
  input  logic              cnt_is_reg,
  input  logic              opnd_is_reg,
  input  logic [DATA_W-1:0] operand,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              z_flag,
  output logic              wr_en,
  output logic [CYC_W-1:0]  cycles
);
  bitop_e            op_e;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;
  logic              alu_wr;
  logic [CYC_W-1:0]  cost;

  logic              vld_d, vld_q;
  logic [DATA_W-1:0] res_d, res_q;
  logic              z_d, z_q;
  logic              wr_d, wr_q;
  logic [CYC_W-1:0]  cyc_d, cyc_q;

  assign op_e = bitop_e'(op_type);

  bitop_mask_dec #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W),
    .NUM_W  (NUM_W)
  ) u_mask (
    .bit_num (bit_num),
    .is_reg  (opnd_is_reg),
    .mask    (mask)
  );

  bitop_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op   (op_e),
    .opnd (operand),
    .mask (mask),
    .res  (alu_res),
    .zero (alu_zero),
    .wr   (alu_wr)
  );

  bitop_cost u_cost (
    .op          (op_e),
    .cnt_is_reg  (cnt_is_reg),
    .opnd_is_reg (opnd_is_reg),
    .cycles      (cost)
  );

  // Next state: load on request, otherwise hold.
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    z_d   = z_q;
    wr_d  = wr_q;
    cyc_d = cyc_q;
    if (in_valid) begin
      res_d = alu_res;
      z_d   = alu_zero;
      wr_d  = alu_wr;
      cyc_d = cost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      z_q   <= 1'b0;
      wr_q  <= 1'b0;
      cyc_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      z_q   <= z_d;
      wr_q  <= wr_d;
      cyc_q <= cyc_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign z_flag    = z_q;
  assign wr_en     = wr_q;
  assign cycles    = cyc_q;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NUM_W  = 8,
  parameter int unsigned CW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op_type,
  input logic [NUM_W-1:0]  bit_num,
  input logic              cnt_is_reg,
  input logic              opnd_is_reg,
  input logic [DATA_W-1:0] operand,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              z_flag,
  input logic              wr_en,
  input logic [CW-1:0]     cycles
);
  localparam int unsigned IDX_W  = $clog2(DATA_W);
  localparam int unsigned BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0] chk_idx;
  logic             sel_bit;
  logic             unused_chk;

  assign chk_idx    = opnd_is_reg ? bit_num[IDX_W-1:0]
                                  : {{(IDX_W-BIDX_W){1'b0}}, bit_num[BIDX_W-1:0]};
  assign sel_bit    = operand[chk_idx];
  assign unused_chk = ^{bit_num[NUM_W-1:IDX_W], cnt_is_reg};

  p_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(z_flag) && $stable(wr_en) && $stable(cycles)));

  p_test_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_type == 2'd0) |=> (!wr_en && result == $past(operand)));

  p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_type != 2'd0) |=> wr_en);

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (z_flag == !$past(sel_bit)));

  p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_type == 2'd1) |=> ($countones(result ^ $past(operand)) == 1));

  p_onebit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($countones(result ^ $past(operand)) <= 1));

  p_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !opnd_is_reg) |=> (result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W])));

  p_cost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cycles[0] == 1'b0 && cycles >= CW'(4) && cycles <= CW'(14)));

endmodule

bind bitop_unit bitop_unit_chk #(
  .DATA_W (DATA_W),
  .BYTE_W (BYTE_W),
  .NUM_W  (NUM_W),
  .CW     (bitop_pkg::CYC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op_type     (op_type),
  .bit_num     (bit_num),
  .cnt_is_reg  (cnt_is_reg),
  .opnd_is_reg (opnd_is_reg),
  .operand     (operand),
  .out_valid   (out_valid),
  .result      (result),
  .z_flag      (z_flag),
  .wr_en       (wr_en),
  .cycles      (cycles)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
  localparam int NV = 14;

  // Stimulus and expected vectors; comments name the requirements covered.
  //  0 test reg creg  (R1 R4 R9)      1 test bit35 reg (R2)
  //  2 flip b31 imm   (R5 R10)        3 clr b0 reg     (R6 R9)
  //  4 set b16 imm    (R7 R10)        5 set mem b10->2 (R3 R7)
  //  6 clr mem b15->7 (R3 R6)         7 test mem b255  (R3 R10)
  //  8 flip mem       (R3 R5 R9)      9 test reg imm   (R10)
  // 10 clr zero bit   (R6 R8)        11 flip b39->7    (R2 R5)
  // 12 set mem b128->0(R3 R7)        13 clr mem creg   (R9)
  localparam logic [1:0]  T_OP   [NV] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2,
                                          2'd0, 2'd1, 2'd0, 2'd2, 2'd1, 2'd3, 2'd2};
  localparam logic [7:0]  T_NUM  [NV] = '{8'd3, 8'd35, 8'd31, 8'd0, 8'd16, 8'd10, 8'd15,
                                          8'd255, 8'd5, 8'd4, 8'd9, 8'd39, 8'd128, 8'd3};
  localparam logic        T_CREG [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                          1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        T_OREG [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0] T_OPND [NV] = '{32'h0000_0008, 32'h0000_0008, 32'h1234_5678,
                                          32'hFFFF_FFFF, 32'h0000_0000, 32'hABCD_0000,
                                          32'h0000_00FF, 32'h0000_0080, 32'h0000_0020,
                                          32'h0000_0000, 32'h0000_0000, 32'hFFFF_FF7F,
                                          32'h0000_0001, 32'h0000_0008};
  localparam logic [31:0] T_RES  [NV] = '{32'h0000_0008, 32'h0000_0008, 32'h9234_5678,
                                          32'hFFFF_FFFE, 32'h0001_0000, 32'hABCD_0004,
                                          32'h0000_007F, 32'h0000_0080, 32'h0000_0000,
                                          32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF,
                                          32'h0000_0001, 32'h0000_0000};
  localparam logic        T_Z    [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0,
                                          1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic        T_WR   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                          1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [4:0]  T_CYC  [NV] = '{5'd6, 5'd6, 5'd12, 5'd10, 5'd12, 5'd8, 5'd12,
                                          5'd8, 5'd8, 5'd10, 5'd10, 5'd12, 5'd12, 5'd8};

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_type;
  logic [7:0]  bit_num;
  logic        cnt_is_reg;
  logic        opnd_is_reg;
  logic [31:0] operand;
  logic        out_valid;
  logic [31:0] result;
  logic        z_flag;
  logic        wr_en;
  logic [4:0]  cycles;

  int checks;
  int failures;
  bit done;

  bitop_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_type     (op_type),
    .bit_num     (bit_num),
    .cnt_is_reg  (cnt_is_reg),
    .opnd_is_reg (opnd_is_reg),
    .operand     (operand),
    .out_valid   (out_valid),
    .result      (result),
    .z_flag      (z_flag),
    .wr_en       (wr_en),
    .cycles      (cycles)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int i);
    in_valid    = 1'b1;
    op_type     = T_OP[i];
    bit_num     = T_NUM[i];
    cnt_is_reg  = T_CREG[i];
    opnd_is_reg = T_OREG[i];
    operand     = T_OPND[i];
  endtask

  function automatic string res_tag(input int i);
    if (!T_OREG[i])            return "R3";
    if (T_NUM[i] >= 8'd32)     return "R2";
    case (T_OP[i])
      2'd0:    return "R1";
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    in_valid = 1'b0; op_type = '0; bit_num = '0;
    cnt_is_reg = 1'b0; opnd_is_reg = 1'b0; operand = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);

    // R12: reset state
    check("R12", "out_valid", 32'(out_valid), 32'd0);
    check("R12", "result", result, 32'd0);
    check("R12", "z_flag/wr_en", {30'd0, z_flag, wr_en}, 32'd0);
    check("R12", "cycles", 32'(cycles), 32'd0);
    rst_n = 1'b1;

    // Table walk, back to back requests
    @(negedge clk);
    drive(0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R11", "out_valid", 32'(out_valid), 32'd1);
      check(res_tag(i), "result", result, T_RES[i]);
      check("R4", "z_flag", 32'(z_flag), 32'(T_Z[i]));
      check(T_WR[i] ? "R8" : "R1", "wr_en", 32'(wr_en), 32'(T_WR[i]));
      check(T_CREG[i] ? "R9" : "R10", "cycles", 32'(cycles), 32'(T_CYC[i]));
      if (i + 1 < NV) drive(i + 1);
      else            in_valid = 1'b0;
    end

    // R11: idle cycle with changed inputs leaves outputs held
    operand = 32'hDEAD_BEEF; op_type = 2'd3; bit_num = 8'd1; opnd_is_reg = 1'b1;
    @(negedge clk);
    check("R11", "out_valid idle", 32'(out_valid), 32'd0);
    check("R11", "result held", result, T_RES[NV-1]);
    check("R11", "cycles held", 32'(cycles), 32'(T_CYC[NV-1]));
    @(negedge clk);
    check("R11", "wr_en held", 32'(wr_en), 32'(T_WR[NV-1]));

    // R5: flip on bit 31 of all ones, immediate, register operand
    in_valid = 1'b1; op_type = 2'd1; bit_num = 8'd63; cnt_is_reg = 1'b0;
    opnd_is_reg = 1'b1; operand = 32'hFFFF_FFFF;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", "flip b63->31", result, 32'h7FFF_FFFF);
    check("R4", "z after flip of one", 32'(z_flag), 32'd0);

    // R3: byte clear on bit 7 with a byte bit number above 7, upper bits kept
    in_valid = 1'b1; op_type = 2'd2; bit_num = 8'd31; cnt_is_reg = 1'b1;
    opnd_is_reg = 1'b0; operand = 32'h8000_0080;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", "byte clear b31->7", result, 32'h8000_0000);
    check("R9", "byte clear cost", 32'(cycles), 32'd8);

    // R12: asynchronous reset mid-stream clears outputs
    #3 rst_n = 1'b0;
    #2;
    check("R12", "async reset result", result, 32'd0);
    check("R12", "async reset valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule